// File: doc/BRIEF.md
# CCD Frame Readout Sequencer

The sequencer produces the timing skeleton for reading one frame out of a CCD sensor. On a start request it captures four settings: the length of a horizontal (pixel) period and of a vertical (line transfer) period, both counted in 200 ns base ticks, and the number of pixels per line and lines per frame, both 12-bit. Each line opens with one vertical transfer period, followed by the programmed number of horizontal pixel periods. The frame lasts ((H×P)+V)×L ticks in total. Pixel and line counts may be larger than the physical sensor, so that overscan and dummy columns are read.

Within every period a step address counts the base ticks from zero. An external pattern memory uses this address, together with the phase flag, to look up the clock waveform levels. Once per pixel period a one-clock conversion trigger is raised for the sampling ADC. The running pixel and line indices are brought out for the capture logic. The base tick is derived from the system clock by a prescaler, which is reset at every start so that every frame has the same phase.

The control is a four-state machine: IDLE (waiting), VERT (vertical transfer period), HORZ (horizontal pixel period) and FINISH (one clock of completion). Its transitions are: IDLE→VERT on an accepted start; VERT→HORZ at the last tick of the vertical period; HORZ→HORZ at the end of a pixel period that is not the last in the line; HORZ→VERT at the end of the last pixel period of a line that is not the last line; HORZ→FINISH at the end of the last pixel period of the last line; FINISH→IDLE unconditionally.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, busy, done, tick and adc_trig are low, and step_addr, pix_idx, line_idx and phase_h are zero.
- R2: A start seen high at a clock edge in IDLE begins a frame. From the next cycle busy is high, phase_h is 0 (vertical), and step_addr, pix_idx and line_idx are 0.
- R3: Each step lasts TICK_NS/CLK_NS clocks, which is 20 by default. tick is high for exactly the last clock of each step and only while a period runs.
- R4: Every line is one vertical period (phase_h=0) of V steps followed by P horizontal periods (phase_h=1) of H steps each, where V, H and P are the values captured at start.
- R5: Within each period step_addr runs 0,1,…,length−1, advancing by one per step.
- R6: pix_idx is 0 during the vertical period and counts 0…P−1 across the horizontal periods of a line. line_idx counts 0…L−1 across the frame.
- R7: adc_trig is high for one clock, coinciding with tick, at step H−1−TRIG_BACK (the last step by default) of every horizontal period, and never during a vertical period.
- R8: busy stays high for exactly ((H×P)+V)×L×(TICK_NS/CLK_NS)+1 clocks per frame.
- R9: done is high for one clock after the final step of the last pixel of the last line, and busy is low in the following clock.
- R10: A start while busy is ignored, and a change of the setting inputs during a frame has no effect on that frame.
- R11: A horizontal or vertical time of 0 is treated as one step.
- R12: A pixel or line count of 0 is treated as one.
- R13: Counts up to 4095 are accepted without wrapping. A frame of 4095 pixels produces 4095 horizontal periods and 4095 triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start request, accepted only in IDLE |
| hpix_time | input | 12 | Pixel period length in base ticks |
| vxfer_time | input | 12 | Line transfer period length in base ticks |
| pix_total | input | 12 | Horizontal periods per line |
| line_total | input | 12 | Lines per frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock completion pulse |
| tick | output | 1 | Base-tick pulse, last clock of each step |
| step_addr | output | 12 | Step index within the current period |
| phase_h | output | 1 | 1 = horizontal period, 0 = vertical period |
| pix_idx | output | 12 | Current pixel index |
| line_idx | output | 12 | Current line index |
| adc_trig | output | 1 | One-clock conversion trigger per pixel |

## Verification
The bench predicts the whole stream of steps for each frame, including phase, indices, step and trigger, and matches it tick by tick. A design that put the vertical period after the pixels, or that dropped or repeated a step at a wrap, breaks the stream at once. The settings of zero are driven to catch a sequencer that stalls or counts 4096 instead of one. A 4095-pixel line catches a counter that wraps early. One frame receives a second start and new settings midway; a design that restarts, or that reloads its settings, changes its busy length or its step stream. The busy length is compared with the frame-time formula, which catches an off-by-one in the prescaler or at a period end.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VERT   = 2'd1,
        ST_HORZ   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

    // Replace a zero setting by one so no period or count can be empty.
    function automatic logic [11:0] at_least_one(input logic [11:0] v);
        return (v == '0) ? 12'd1 : v;
    endfunction

endpackage

// File: rtl/ccdseq_prescaler.sv
module ccdseq_prescaler #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ccdseq_wrap_ctr.sv
module ccdseq_wrap_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] len,
    output logic [W-1:0] value,
    output logic         last
);
    logic [W-1:0] val_q;

    assign last  = (val_q == len - 1'b1);
    assign value = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clear) begin
            val_q <= '0;
        end else if (adv) begin
            val_q <= last ? '0 : val_q + 1'b1;
        end
    end
endmodule

// File: rtl/ccdseq_cfg_latch.sv
module ccdseq_cfg_latch #(
    parameter int TW = 12,
    parameter int CW = 12,
    parameter int TRIG_BACK = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] h_in,
    input  logic [TW-1:0] v_in,
    input  logic [CW-1:0] p_in,
    input  logic [CW-1:0] l_in,
    output logic [TW-1:0] h_len,
    output logic [TW-1:0] v_len,
    output logic [CW-1:0] p_cnt,
    output logic [CW-1:0] l_cnt,
    output logic [TW-1:0] trig_step
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_len <= TW'(1);
            v_len <= TW'(1);
            p_cnt <= CW'(1);
            l_cnt <= CW'(1);
        end else if (load) begin
            h_len <= (h_in == '0) ? TW'(1) : h_in;
            v_len <= (v_in == '0) ? TW'(1) : v_in;
            p_cnt <= (p_in == '0) ? CW'(1) : p_in;
            l_cnt <= (l_in == '0) ? CW'(1) : l_in;
        end
    end

    generate
        if (TRIG_BACK == 0) begin : g_trig_last
            assign trig_step = h_len - 1'b1;
        end else begin : g_trig_back
            localparam logic [TW-1:0] BACK = TW'(TRIG_BACK);
            assign trig_step = (h_len > BACK) ? (h_len - 1'b1 - BACK) : '0;
        end
    endgenerate
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccdseq_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int TICK_NS   = 200,
    parameter int TIME_W    = 12,
    parameter int COUNT_W   = 12,
    parameter int TRIG_BACK = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [TIME_W-1:0]  hpix_time,
    input  logic [TIME_W-1:0]  vxfer_time,
    input  logic [COUNT_W-1:0] pix_total,
    input  logic [COUNT_W-1:0] line_total,
    output logic               busy,
    output logic               done,
    output logic               tick,
    output logic [TIME_W-1:0]  step_addr,
    output logic               phase_h,
    output logic [COUNT_W-1:0] pix_idx,
    output logic [COUNT_W-1:0] line_idx,
    output logic               adc_trig
);
    localparam int DIV = (TICK_NS / CLK_NS < 1) ? 1 : TICK_NS / CLK_NS;

    seq_state_t state_q, state_d;

    logic               start_acc;
    logic               running;
    logic               tick_w;
    logic [TIME_W-1:0]  h_len, v_len, trig_step, period_len;
    logic [COUNT_W-1:0] p_cnt, l_cnt;
    logic [TIME_W-1:0]  step_w;
    logic [COUNT_W-1:0] pix_w, line_w;
    logic               step_last, pix_last, line_last;
    logic               period_end, line_end;

    assign start_acc  = (state_q == ST_IDLE) && start;
    assign running    = (state_q == ST_VERT) || (state_q == ST_HORZ);
    assign period_len = (state_q == ST_HORZ) ? h_len : v_len;
    assign period_end = tick_w && step_last;
    assign line_end   = period_end && (state_q == ST_HORZ) && pix_last;

    ccdseq_cfg_latch #(
        .TW(TIME_W), .CW(COUNT_W), .TRIG_BACK(TRIG_BACK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(start_acc),
        .h_in(hpix_time), .v_in(vxfer_time),
        .p_in(pix_total), .l_in(line_total),
        .h_len(h_len), .v_len(v_len), .p_cnt(p_cnt), .l_cnt(l_cnt),
        .trig_step(trig_step)
    );

    ccdseq_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .run(running),
        .tick(tick_w)
    );

    ccdseq_wrap_ctr #(.W(TIME_W)) u_step (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .adv(tick_w),
        .len(period_len), .value(step_w), .last(step_last)
    );

    ccdseq_wrap_ctr #(.W(COUNT_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .clear(start_acc),
        .adv(period_end && (state_q == ST_HORZ)),
        .len(p_cnt), .value(pix_w), .last(pix_last)
    );

    ccdseq_wrap_ctr #(.W(COUNT_W)) u_line (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .adv(line_end),
        .len(l_cnt), .value(line_w), .last(line_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_VERT;
            ST_VERT:   if (period_end) state_d = ST_HORZ;
            ST_HORZ: begin
                if (line_end) state_d = line_last ? ST_FINISH : ST_VERT;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        phase_h   = 1'b0;
        tick      = 1'b0;
        adc_trig  = 1'b0;
        step_addr = '0;
        pix_idx   = '0;
        line_idx  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VERT: begin
                busy      = 1'b1;
                tick      = tick_w;
                step_addr = step_w;
                line_idx  = line_w;
            end
            ST_HORZ: begin
                busy      = 1'b1;
                phase_h   = 1'b1;
                tick      = tick_w;
                step_addr = step_w;
                pix_idx   = pix_w;
                line_idx  = line_w;
                adc_trig  = tick_w && (step_w == trig_step);
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk #(
    parameter int TIME_W  = 12,
    parameter int COUNT_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               tick,
    input logic [TIME_W-1:0]  step_addr,
    input logic               phase_h,
    input logic [COUNT_W-1:0] pix_idx,
    input logic [COUNT_W-1:0] line_idx,
    input logic               adc_trig
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r2_frame_opens_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!phase_h && step_addr == '0 && pix_idx == '0 && line_idx == '0));

    a_r7_trig_on_hstep: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> (phase_h && tick));

    a_r3_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (busy && !done));

    a_r5_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(step_addr));

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r6_pix_zero_vert: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !phase_h) |-> (pix_idx == '0));
endmodule

bind ccd_readout_seq ccd_readout_seq_chk #(.TIME_W(TIME_W), .COUNT_W(COUNT_W)) i_chk (.*);

// File: tb/test_ccd_readout_seq.sv
module test_ccd_readout_seq;
    localparam int CLK_NS  = 10;
    localparam int TICK_NS = 200;
    localparam int DIV     = TICK_NS / CLK_NS;

    typedef struct packed {
        logic        ph;
        logic [11:0] line;
        logic [11:0] pix;
        logic [11:0] step;
        logic        trig;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] hpix_time = '0, vxfer_time = '0, pix_total = '0, line_total = '0;
    logic        busy, done, tick, phase_h, adc_trig;
    logic [11:0] step_addr, pix_idx, line_idx;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   gap = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    ccd_readout_seq i_ccd_readout_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hpix_time(hpix_time), .vxfer_time(vxfer_time),
        .pix_total(pix_total), .line_total(line_total),
        .busy(busy), .done(done), .tick(tick), .step_addr(step_addr),
        .phase_h(phase_h), .pix_idx(pix_idx), .line_idx(line_idx),
        .adc_trig(adc_trig)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops one expected step per tick (R3 R4 R5 R6 R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) gap++;
            else      gap = 0;
            if (adc_trig && !tick) check(0, "R7", "trigger off tick", 1, 0);
            if (tick) begin
                check(gap == DIV, "R3", "clocks per step", gap, DIV);
                gap = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected step", step_addr, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(phase_h == e.ph, "R4", "phase", phase_h, e.ph);
                    check(step_addr == e.step, "R5", "step", step_addr, e.step);
                    check(pix_idx == e.pix && line_idx == e.line, "R6", "pix/line",
                          {pix_idx, line_idx}, {e.pix, e.line});
                    check(adc_trig == e.trig, "R7", "trigger", adc_trig, e.trig);
                end
            end
        end
    end

    // Driver: predicts the step stream, runs one frame, checks its length
    task automatic run_frame(input int h, input int v, input int p, input int l,
                             input bit poke, input string req);
        int hl, vl, pc, lc, busy_cnt, done_cnt;
        longint expect_busy;
        hl = (h == 0) ? 1 : h;   // R11
        vl = (v == 0) ? 1 : v;
        pc = (p == 0) ? 1 : p;   // R12
        lc = (l == 0) ? 1 : l;
        for (int ln = 0; ln < lc; ln++) begin
            for (int s = 0; s < vl; s++)
                exp_q.push_back('{1'b0, 12'(ln), 12'd0, 12'(s), 1'b0});
            for (int px = 0; px < pc; px++)
                for (int s = 0; s < hl; s++)
                    exp_q.push_back('{1'b1, 12'(ln), 12'(px), 12'(s), (s == hl - 1)});
        end
        expect_busy = (longint'(hl) * pc + vl) * lc * DIV + 1;   // R8
        @(negedge clk);
        hpix_time = 12'(h); vxfer_time = 12'(v); pix_total = 12'(p); line_total = 12'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !phase_h && step_addr == 0 && pix_idx == 0 && line_idx == 0,
              "R2", "frame opening", {busy, phase_h, step_addr}, {1'b1, 1'b0, 12'd0});
        busy_cnt = 0;
        done_cnt = 0;
        while (busy) begin
            busy_cnt++;
            if (done) done_cnt++;
            if (poke && busy_cnt == 7) begin   // R10
                start = 1'b1;
                hpix_time = 12'd9; vxfer_time = 12'd9; pix_total = 12'd9; line_total = 12'd9;
            end
            if (poke && busy_cnt == 8) start = 1'b0;
            @(negedge clk);
        end
        check(busy_cnt == expect_busy, req, "busy clocks (R8)", busy_cnt, expect_busy);
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        check(exp_q.size() == 0, req, "steps left over", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(!busy && !done, "R9", "idle after done", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !tick && !adc_trig && !phase_h &&
              step_addr == 0 && pix_idx == 0 && line_idx == 0,
              "R1", "reset outputs", {busy, done, tick, adc_trig}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy, "R1", "idle after reset", busy, 0);

        run_frame(3, 2, 4, 3, 0, "R4");
        run_frame(0, 0, 2, 2, 0, "R11");
        run_frame(2, 1, 0, 0, 0, "R12");
        run_frame(2, 3, 3, 2, 1, "R10");
        run_frame(5, 4, 1, 1, 0, "R8");
        run_frame(1, 1, 4095, 1, 0, "R13");
        report();
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        check(0, "R8", "watchdog expired", 0, 1);
        report();
    end
endmodule